// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for one display pipe. A simple write port loads the following values:

- line and frame lengths;
- the edges of the visible window and of the addressable picture inside it;
- sync pulse widths and their polarities;
- an interlace mode and an advanced-request mode;
- two colours;
- a run flag and a blank-data flag.

A horizontal counter and a vertical counter run from these values. Each line and each frame begin at the leading edge of sync.

From the counters the block drives sync, blank and data-enable strobes. A colour multiplexer picks, for every pixel, one of three sources: the blank colour, the overscan colour, or the incoming pixel data. The block also reports the live counter position, a field parity flag, a running frame count and the line offset at which an advanced fetch request should start.

Timing values are written into a pending copy. They move into the working copy only at a frame boundary, so a frame that is already running never changes shape part-way through.

Top module: `crtc_tg`

## Requirements
- R1: Address 0 bits [CNT_W-1:0] hold the line length minus one (H_TOTAL), and address 1 holds the frame height minus one (V_TOTAL). While running, pos_h counts 0..H_TOTAL and then wraps to 0. pos_v advances at each line end and wraps to 0 after V_TOTAL.
- R2: Addresses 6 (horizontal) and 7 (vertical) hold the sync end in bits [CNT_W-1:0] and the polarity in bit 31.
  - A sync pulse is active while its counter is below the sync end, so the pulse width equals the sync end.
  - Polarity 0 drives the active level high; polarity 1 drives it low.
  - The inactive level is the opposite of the active level.
- R3: Addresses 2 (horizontal) and 3 (vertical) hold the blank end in bits [CNT_W-1:0] and the blank start in bits [CNT_W+15:16]. hblank/vblank are 1 when the counter is at or above the blank start, or below the blank end. de is 1 only while running with neither blank set.
- R4: Addresses 4 and 5 hold the addressable start in bits [CNT_W-1:0] and the exclusive addressable end in bits [CNT_W+15:16].
  - Inside the visible window but outside the addressable rectangle: px_sel is 1 and px_out is the overscan colour (address 11).
  - Inside the rectangle: px_sel is 2 and px_out equals px_in.
- R5: Outside the visible window px_sel is 0 and px_out is the blank colour (address 10). Colours pack B/Cb in [COLOR_W-1:0], G/Y in the next COLOR_W bits and R/Cr above that. Colour writes apply from the next clock.
- R6: Address 9 bit 30 (blank-data enable) forces px_sel to 0 and px_out to the blank colour on every pixel. Clearing the bit restores normal selection.
- R7: Address 9 bit 31 is the run flag.
  - While it is clear: both counters and the field flag are held at 0, syncs sit at their inactive level, both blanks are 1, de is 0 and frame_cnt holds.
  - After it is set, counting starts from position 0,0.
- R8: frame_cnt increments by exactly one at the last pixel of every frame (of every field when interlaced) and changes at no other time.
- R9: adv_line is 2 when address 8 bit 1 is clear. When that bit is set, adv_line is 3 if (V_TOTAL+1-vertical blank start)+vertical sync end is at most 3, and 4 otherwise.
- R10: Writes to addresses 0..8 go to a pending copy. The working copy loads the pending copy at the clock edge that ends a frame, and at every edge while the run flag is clear.
- R11: Address 8 bit 0 enables interlace.
  - While it is enabled, field toggles at each frame end. A frame with field 1 has one extra line (pos_v = V_TOTAL+1) that counts 0..floor(H_TOTAL/2).
  - When a frame ends with interlace off, field returns to 0.
- R12: After reset every register is 0 and the block is stopped: pos_h=pos_v=0, frame_cnt=0, px_sel=0, adv_line=2, de=0, hblank=vblank=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| px_in | input | 3*COLOR_W | Incoming pixel data |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking (also the status flag) |
| de | output | 1 | Data enable |
| px_sel | output | 2 | Colour source: 0 blank, 1 overscan, 2 pixel |
| px_out | output | 3*COLOR_W | Selected colour |
| field | output | 1 | Field parity |
| frame_cnt | output | FRAME_W | Frame counter |
| pos_h | output | CNT_W | Live horizontal position |
| pos_v | output | CNT_W | Live vertical position |
| adv_line | output | 3 | Advanced request start line |

## Verification
The bound assertions check, on every cycle, the properties that hold in every state:
- the horizontal bound and the stillness of the line count within a line;
- the single-step frame counter;
- counters pinned at zero while stopped;
- field clearing at a non-interlaced frame end;
- blank-data forcing and the link between de and the colour source.

Only the bench's scenarios show the exact pixel and line of every sync, blank and overscan edge under each register set. They also show:
- that a mid-frame write waits for the boundary;
- the extra half line of odd fields;
- the three advanced-request outcomes.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
    localparam int REG_AW = 4;
    localparam int REG_DW = 32;
    localparam int HI_LSB = 16;

    localparam logic [REG_AW-1:0] A_HTOT = 4'd0;
    localparam logic [REG_AW-1:0] A_VTOT = 4'd1;
    localparam logic [REG_AW-1:0] A_HBLK = 4'd2;
    localparam logic [REG_AW-1:0] A_VBLK = 4'd3;
    localparam logic [REG_AW-1:0] A_HACT = 4'd4;
    localparam logic [REG_AW-1:0] A_VACT = 4'd5;
    localparam logic [REG_AW-1:0] A_HSYN = 4'd6;
    localparam logic [REG_AW-1:0] A_VSYN = 4'd7;
    localparam logic [REG_AW-1:0] A_MODE = 4'd8;
    localparam logic [REG_AW-1:0] A_CTRL = 4'd9;
    localparam logic [REG_AW-1:0] A_BCOL = 4'd10;
    localparam logic [REG_AW-1:0] A_OCOL = 4'd11;

    typedef enum logic [1:0] {
        SEL_BLANK    = 2'd0,
        SEL_OVERSCAN = 2'd1,
        SEL_PIXEL    = 2'd2
    } px_sel_e;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int COLOR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_AW-1:0]      wr_addr,
    input  logic [REG_DW-1:0]      wr_data,
    input  logic                   frame_end,
    output logic [CNT_W-1:0]       h_total,
    output logic [CNT_W-1:0]       v_total,
    output logic [CNT_W-1:0]       hb_start,
    output logic [CNT_W-1:0]       hb_end,
    output logic [CNT_W-1:0]       vb_start,
    output logic [CNT_W-1:0]       vb_end,
    output logic [CNT_W-1:0]       ha_start,
    output logic [CNT_W-1:0]       ha_end,
    output logic [CNT_W-1:0]       va_start,
    output logic [CNT_W-1:0]       va_end,
    output logic [CNT_W-1:0]       hs_end,
    output logic [CNT_W-1:0]       vs_end,
    output logic                   hs_pol,
    output logic                   vs_pol,
    output logic                   ilace,
    output logic                   adv_mode,
    output logic                   en,
    output logic                   bde,
    output logic [3*COLOR_W-1:0]   bcol,
    output logic [3*COLOR_W-1:0]   ocol
);
    localparam int COL_W = 3 * COLOR_W;

    typedef struct packed {
        logic [CNT_W-1:0] h_total;
        logic [CNT_W-1:0] v_total;
        logic [CNT_W-1:0] hb_start;
        logic [CNT_W-1:0] hb_end;
        logic [CNT_W-1:0] vb_start;
        logic [CNT_W-1:0] vb_end;
        logic [CNT_W-1:0] ha_start;
        logic [CNT_W-1:0] ha_end;
        logic [CNT_W-1:0] va_start;
        logic [CNT_W-1:0] va_end;
        logic [CNT_W-1:0] hs_end;
        logic [CNT_W-1:0] vs_end;
        logic             hs_pol;
        logic             vs_pol;
        logic             ilace;
        logic             adv;
    } timing_t;

    typedef struct packed {
        timing_t          pend;
        timing_t          act;
        logic             en;
        logic             bde;
        logic [COL_W-1:0] bcol;
        logic [COL_W-1:0] ocol;
    } regs_t;

    regs_t q, d;
    logic [CNT_W-1:0] lo_f, hi_f;

    always_comb begin
        lo_f = wr_data[CNT_W-1:0];
        hi_f = wr_data[HI_LSB+CNT_W-1:HI_LSB];
        d = q;
        // working copy follows pending copy at frame end or while stopped
        if (!q.en || frame_end) d.act = q.pend;
        if (wr_en) begin
            case (wr_addr)
                A_HTOT: d.pend.h_total = lo_f;
                A_VTOT: d.pend.v_total = lo_f;
                A_HBLK: begin d.pend.hb_end = lo_f; d.pend.hb_start = hi_f; end
                A_VBLK: begin d.pend.vb_end = lo_f; d.pend.vb_start = hi_f; end
                A_HACT: begin d.pend.ha_start = lo_f; d.pend.ha_end = hi_f; end
                A_VACT: begin d.pend.va_start = lo_f; d.pend.va_end = hi_f; end
                A_HSYN: begin d.pend.hs_end = lo_f; d.pend.hs_pol = wr_data[REG_DW-1]; end
                A_VSYN: begin d.pend.vs_end = lo_f; d.pend.vs_pol = wr_data[REG_DW-1]; end
                A_MODE: begin d.pend.ilace = wr_data[0]; d.pend.adv = wr_data[1]; end
                A_CTRL: begin d.en = wr_data[REG_DW-1]; d.bde = wr_data[REG_DW-2]; end
                A_BCOL: d.bcol = wr_data[COL_W-1:0];
                A_OCOL: d.ocol = wr_data[COL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign h_total  = q.act.h_total;
    assign v_total  = q.act.v_total;
    assign hb_start = q.act.hb_start;
    assign hb_end   = q.act.hb_end;
    assign vb_start = q.act.vb_start;
    assign vb_end   = q.act.vb_end;
    assign ha_start = q.act.ha_start;
    assign ha_end   = q.act.ha_end;
    assign va_start = q.act.va_start;
    assign va_end   = q.act.va_end;
    assign hs_end   = q.act.hs_end;
    assign vs_end   = q.act.vs_end;
    assign hs_pol   = q.act.hs_pol;
    assign vs_pol   = q.act.vs_pol;
    assign ilace    = q.act.ilace;
    assign adv_mode = q.act.adv;
    assign en       = q.en;
    assign bde      = q.bde;
    assign bcol     = q.bcol;
    assign ocol     = q.ocol;
endmodule

// File: rtl/crtc_counter.sv
module crtc_counter #(
    parameter int CNT_W   = 12,
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [CNT_W-1:0]   h_total,
    input  logic [CNT_W-1:0]   v_total,
    input  logic               ilace,
    output logic [CNT_W-1:0]   pos_h,
    output logic [CNT_W-1:0]   pos_v,
    output logic               field,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               frame_end
);
    typedef struct packed {
        logic [CNT_W-1:0]   h;
        logic [CNT_W-1:0]   v;
        logic               field;
        logic [FRAME_W-1:0] frame;
    } cnt_t;

    cnt_t q, d;
    logic             half_line;
    logic [CNT_W-1:0] h_last;
    logic             line_end;

    always_comb begin
        // the extra line of an odd interlaced field is half as long
        half_line = (q.v > v_total);
        h_last    = half_line ? (h_total >> 1) : h_total;
        line_end  = (q.h == h_last);
        frame_end = en && line_end &&
                    (half_line || ((q.v == v_total) && !(ilace && q.field)));
        d = q;
        if (!en) begin
            d.h     = '0;
            d.v     = '0;
            d.field = 1'b0;
        end else if (line_end) begin
            d.h = '0;
            d.v = frame_end ? '0 : q.v + 1'b1;
            if (frame_end) begin
                d.field = ilace ? ~q.field : 1'b0;
                d.frame = q.frame + 1'b1;
            end
        end else begin
            d.h = q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pos_h     = q.h;
    assign pos_v     = q.v;
    assign field     = q.field;
    assign frame_cnt = q.frame;
endmodule

// File: rtl/crtc_axis.sv
module crtc_axis #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] b_start,
    input  logic [CNT_W-1:0] b_end,
    input  logic [CNT_W-1:0] a_start,
    input  logic [CNT_W-1:0] a_end,
    input  logic [CNT_W-1:0] s_end,
    output logic             blank,
    output logic             in_act,
    output logic             sync_on
);
    always_comb begin
        // visible between blank end and blank start; blank wraps through 0
        blank   = !((cnt >= b_end) && (cnt < b_start));
        in_act  = (cnt >= a_start) && (cnt < a_end);
        sync_on = (cnt < s_end);
    end
endmodule

// File: rtl/crtc_tg.sv
module crtc_tg
    import crtc_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int COLOR_W = 10,
    parameter int FRAME_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [3:0]             wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [3*COLOR_W-1:0]   px_in,
    output logic                   hsync,
    output logic                   vsync,
    output logic                   hblank,
    output logic                   vblank,
    output logic                   de,
    output logic [1:0]             px_sel,
    output logic [3*COLOR_W-1:0]   px_out,
    output logic                   field,
    output logic [FRAME_W-1:0]     frame_cnt,
    output logic [CNT_W-1:0]       pos_h,
    output logic [CNT_W-1:0]       pos_v,
    output logic [2:0]             adv_line
);
    localparam int NAX = 2;

    logic [CNT_W-1:0] h_total, v_total, hb_start, hb_end, vb_start, vb_end;
    logic [CNT_W-1:0] ha_start, ha_end, va_start, va_end, hs_end, vs_end;
    logic             hs_pol, vs_pol, ilace, adv_mode, en, bde, frame_end;
    logic [3*COLOR_W-1:0] bcol, ocol;

    crtc_regs #(.CNT_W(CNT_W), .COLOR_W(COLOR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end),
        .h_total(h_total), .v_total(v_total),
        .hb_start(hb_start), .hb_end(hb_end), .vb_start(vb_start), .vb_end(vb_end),
        .ha_start(ha_start), .ha_end(ha_end), .va_start(va_start), .va_end(va_end),
        .hs_end(hs_end), .vs_end(vs_end), .hs_pol(hs_pol), .vs_pol(vs_pol),
        .ilace(ilace), .adv_mode(adv_mode), .en(en), .bde(bde),
        .bcol(bcol), .ocol(ocol)
    );

    crtc_counter #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .h_total(h_total), .v_total(v_total),
        .ilace(ilace), .pos_h(pos_h), .pos_v(pos_v), .field(field),
        .frame_cnt(frame_cnt), .frame_end(frame_end)
    );

    logic [CNT_W-1:0] ax_cnt [NAX];
    logic [CNT_W-1:0] ax_bs  [NAX];
    logic [CNT_W-1:0] ax_be  [NAX];
    logic [CNT_W-1:0] ax_as  [NAX];
    logic [CNT_W-1:0] ax_ae  [NAX];
    logic [CNT_W-1:0] ax_se  [NAX];
    logic             ax_blank [NAX];
    logic             ax_act   [NAX];
    logic             ax_sync  [NAX];

    assign ax_cnt[0] = pos_h;    assign ax_cnt[1] = pos_v;
    assign ax_bs[0]  = hb_start; assign ax_bs[1]  = vb_start;
    assign ax_be[0]  = hb_end;   assign ax_be[1]  = vb_end;
    assign ax_as[0]  = ha_start; assign ax_as[1]  = va_start;
    assign ax_ae[0]  = ha_end;   assign ax_ae[1]  = va_end;
    assign ax_se[0]  = hs_end;   assign ax_se[1]  = vs_end;

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        crtc_axis #(.CNT_W(CNT_W)) u_axis (
            .cnt(ax_cnt[g]), .b_start(ax_bs[g]), .b_end(ax_be[g]),
            .a_start(ax_as[g]), .a_end(ax_ae[g]), .s_end(ax_se[g]),
            .blank(ax_blank[g]), .in_act(ax_act[g]), .sync_on(ax_sync[g])
        );
    end

    px_sel_e          sel;
    logic [CNT_W:0]   fp_sum;

    always_comb begin
        hsync  = en ? (ax_sync[0] ^ hs_pol) : hs_pol;
        vsync  = en ? (ax_sync[1] ^ vs_pol) : vs_pol;
        hblank = !en || ax_blank[0];
        vblank = !en || ax_blank[1];
        de     = en && !ax_blank[0] && !ax_blank[1];
        if (!de || bde)                   sel = SEL_BLANK;
        else if (ax_act[0] && ax_act[1])  sel = SEL_PIXEL;
        else                              sel = SEL_OVERSCAN;
        case (sel)
            SEL_PIXEL:    px_out = px_in;
            SEL_OVERSCAN: px_out = ocol;
            default:      px_out = bcol;
        endcase
        px_sel = sel;
        // front porch plus sync width, in lines
        fp_sum = {1'b0, v_total} + {{CNT_W{1'b0}}, 1'b1}
               - {1'b0, vb_start} + {1'b0, vs_end};
        if (!adv_mode)                         adv_line = 3'd2;
        else if (fp_sum <= (CNT_W+1)'(3))      adv_line = 3'd3;
        else                                   adv_line = 3'd4;
    end
endmodule

// File: rtl/crtc_tg_chk.sv
module crtc_tg_chk
    import crtc_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int COLOR_W = 10,
    parameter int FRAME_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en,
    input logic                   bde,
    input logic                   ilace,
    input logic                   frame_end,
    input logic [CNT_W-1:0]       h_total,
    input logic [CNT_W-1:0]       v_total,
    input logic [CNT_W-1:0]       pos_h,
    input logic [CNT_W-1:0]       pos_v,
    input logic                   field,
    input logic [FRAME_W-1:0]     frame_cnt,
    input logic                   de,
    input logic [1:0]             px_sel,
    input logic [3*COLOR_W-1:0]   px_out,
    input logic [3*COLOR_W-1:0]   bcol
);
    assert_h_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> pos_h <= h_total);

    assert_v_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pos_h != h_total && pos_v <= v_total) |=> $stable(pos_v));

    assert_frame_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (frame_cnt == $past(frame_cnt)) ||
                 (frame_cnt == $past(frame_cnt) + 1'b1));

    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pos_h == '0) && (pos_v == '0) && !field);

    assert_field_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !ilace) |=> !field);

    assert_bde_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bde |-> (px_out == bcol) && (px_sel == SEL_BLANK));

    assert_de_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (px_sel != SEL_BLANK) || bde);
endmodule

bind crtc_tg crtc_tg_chk #(.CNT_W(CNT_W), .COLOR_W(COLOR_W), .FRAME_W(FRAME_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .bde(bde), .ilace(ilace),
    .frame_end(frame_end), .h_total(h_total), .v_total(v_total),
    .pos_h(pos_h), .pos_v(pos_v), .field(field), .frame_cnt(frame_cnt),
    .de(de), .px_sel(px_sel), .px_out(px_out), .bcol(bcol)
);

// File: tb/test_crtc_tg.sv
`timescale 1ns/1ps
module test_crtc_tg;
    localparam int CW = 12;
    localparam int KW = 10;
    localparam int FW = 16;
    localparam int CMASK = (1 << CW) - 1;
    localparam longint PMASK = (64'd1 << (3*KW)) - 1;

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [3:0] wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic [3*KW-1:0] px_in = 0;
    logic hsync, vsync, hblank, vblank, de, field;
    logic [1:0] px_sel;
    logic [3*KW-1:0] px_out;
    logic [FW-1:0] frame_cnt;
    logic [CW-1:0] pos_h, pos_v;
    logic [2:0] adv_line;

    crtc_tg #(.CNT_W(CW), .COLOR_W(KW), .FRAME_W(FW)) i_crtc_tg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .px_in(px_in), .hsync(hsync), .vsync(vsync),
        .hblank(hblank), .vblank(vblank), .de(de), .px_sel(px_sel),
        .px_out(px_out), .field(field), .frame_cnt(frame_cnt),
        .pos_h(pos_h), .pos_v(pos_v), .adv_line(adv_line));

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0, maxv = 0;
    bit comparing = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference state
    int p[9], a[9];
    int m_en, m_bde, m_h, m_v, m_fld, m_fc;
    longint m_bc, m_oc;
    int ht, vt, il, xl, hl, le, fe;

    function automatic int lo(int x); return x & CMASK; endfunction
    function automatic int hi(int x); return (x >> 16) & CMASK; endfunction
    function automatic int b31(int x); return (x >> 31) & 1; endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) begin p[i] = 0; a[i] = 0; end
            m_en = 0; m_bde = 0; m_h = 0; m_v = 0; m_fld = 0; m_fc = 0;
            m_bc = 0; m_oc = 0;
        end else begin
            ht = lo(a[0]); vt = lo(a[1]); il = a[8] & 1;
            xl = (m_v > vt);
            hl = xl ? ht / 2 : ht;
            le = (m_h == hl);
            fe = m_en && le && (xl || (m_v == vt && !(il && m_fld)));
            if (!m_en) begin m_h = 0; m_v = 0; m_fld = 0; end
            else if (le) begin
                m_h = 0;
                m_v = fe ? 0 : m_v + 1;
                if (fe) begin m_fld = il ? 1 - m_fld : 0; m_fc = (m_fc + 1) % (1 << FW); end
            end else m_h = m_h + 1;
            if (!m_en || fe) for (int i = 0; i < 9; i++) a[i] = p[i];
            if (wr_en) begin
                if (wr_addr <= 8) p[wr_addr] = wr_data;
                else if (wr_addr == 9) begin m_en = b31(wr_data); m_bde = (wr_data >> 30) & 1; end
                else if (wr_addr == 10) m_bc = longint'(wr_data) & PMASK;
                else if (wr_addr == 11) m_oc = longint'(wr_data) & PMASK;
            end
        end
    end

    // compare against the reference away from the active edge
    always @(negedge clk) if (comparing) begin
        int hb, vb, e_de, e_sel, inact, sum, e_adv;
        longint e_px;
        hb = !(m_h >= lo(a[2]) && m_h < hi(a[2]));
        vb = !(m_v >= lo(a[3]) && m_v < hi(a[3]));
        e_de = m_en && !hb && !vb;
        inact = (m_h >= lo(a[4]) && m_h < hi(a[4]) && m_v >= lo(a[5]) && m_v < hi(a[5]));
        e_sel = (!e_de || m_bde) ? 0 : (inact ? 2 : 1);
        e_px = (e_sel == 2) ? longint'(px_in) : (e_sel == 1 ? m_oc : m_bc);
        sum = lo(a[1]) + 1 - hi(a[3]) + lo(a[7]);
        e_adv = ((a[8] >> 1) & 1) ? (sum <= 3 ? 3 : 4) : 2;
        chk("R1 R7 R10 pos_h", pos_h, m_h);
        chk("R1 R7 R11 pos_v", pos_v, m_v);
        chk("R2 hsync", hsync, m_en ? ((m_h < lo(a[6])) ^ b31(a[6])) : b31(a[6]));
        chk("R2 vsync", vsync, m_en ? ((m_v < lo(a[7])) ^ b31(a[7])) : b31(a[7]));
        chk("R3 hblank", hblank, m_en ? hb : 1);
        chk("R3 vblank", vblank, m_en ? vb : 1);
        chk("R3 de", de, e_de);
        chk("R4 R5 R6 px_sel", px_sel, e_sel);
        chk("R4 R5 R6 px_out", px_out, e_px);
        chk("R8 frame_cnt", frame_cnt, m_fc);
        chk("R9 adv_line", adv_line, e_adv);
        chk("R11 field", field, m_fld);
        if (pos_v > maxv) maxv = pos_v;
    end

    always @(posedge clk) begin #1; px_in = 30'($urandom()); end

    task automatic wr(input int addr, input int data);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = addr[3:0]; wr_data = data;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic idle(input int n); repeat (n) @(posedge clk); endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog act=%0d exp=0", checks);
        summary();
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R12: reset state
        chk("R12 pos_h", pos_h, 0);
        chk("R12 pos_v", pos_v, 0);
        chk("R12 frame_cnt", frame_cnt, 0);
        chk("R12 px_sel", px_sel, 0);
        chk("R12 adv_line", adv_line, 2);
        chk("R12 de", de, 0);
        chk("R12 blanks", {hblank, vblank}, 3);
        comparing = 1;
        // progressive frame: 20 x 12
        wr(0, 19); wr(1, 11);
        wr(2, (16 << 16) | 4);  wr(3, (10 << 16) | 2);
        wr(4, (14 << 16) | 6);  wr(5, (9 << 16) | 3);
        wr(6, 2); wr(7, 1);
        wr(8, 2);                             // advanced, sum = 3
        wr(10, 30'h0010_0401); wr(11, 30'h2AA_5555);
        wr(9, 32'h8000_0000);
        idle(730);
        // R10: mid-frame reshape waits for the boundary
        idle(37);
        wr(0, 23); wr(2, (20 << 16) | 5); wr(4, (17 << 16) | 7);
        idle(700);
        // R2: inverted polarity, wider vsync; R9 -> 4
        wr(6, 32'h8000_0003); wr(7, 32'h8000_0003);
        idle(600);
        // R6: blank-data forcing and release
        wr(9, 32'hC000_0000); idle(300);
        wr(9, 32'h8000_0000); idle(300);
        // R11: interlace
        maxv = 0;
        wr(8, 3); idle(1300);
        chk("R11 extra line reached", maxv, 12);
        wr(8, 0); idle(700);
        // R7: stop mid-frame, restart
        idle(53);
        wr(9, 0); idle(20);
        @(negedge clk);
        chk("R7 stopped pos_h", pos_h, 0);
        chk("R7 stopped de", de, 0);
        wr(9, 32'h8000_0000); idle(600);
        // R9: legacy mode
        wr(8, 0); idle(400);
        comparing = 0;
        summary();
        $finish;
    end
endmodule